// File: doc/BRIEF.md
# Prescaled Clock Output and Countdown Timer

This block takes the free-running oscillator waveform of a real-time clock (32.768 kHz by default) and does two things with it. It drives a clock-out pin with a gated square wave at one of four power-of-two rates. It also runs an 8-bit countdown timer that decrements on the ticks of one of four source rates, the slowest of which is one tick per minute. When the countdown expires, the timer sets a sticky flag, reloads itself, and can pull an active-low interrupt line. The line can either stay low until software clears the flag or drop for one source period only.

All configuration goes through a byte-wide register port that is synchronous to the system clock. The oscillator input is assumed to be sampled in the same clock domain, and only its rising edges drive the internal prescaler. Two parameters set the design's view of time: `OSC_LOG2` is the base-2 logarithm of the oscillator frequency (minimum 12), and `SEC_PER_MIN` is the number of 1 Hz ticks that make one minute tick (minimum 2).

Top module: `rtc_prescale_timer`

## Requirements
- R1: After reset every register reads 0x00, `clkOut` is low and `intN` is high.
- R2: Register map. Address 0x01 is the interrupt control register: bit 4 selects pulse mode when 1, bit 2 is the timer flag, and bit 0 is the timer interrupt enable. Address 0x0D is the clock-out control register: bit 7 is the enable and bits [1:0] are the rate select. Address 0x0E is the timer control register: bit 7 is the enable and bits [1:0] are the source select. Address 0x0F is the count register. All other bits read 0. Any other address reads 0x00, and writes to it change nothing.
- R3: While the clock-out enable is 0, `clkOut` stays low.
- R4: With clock-out enabled, the rate select gives the oscillator frequency divided by 1, 2^(OSC_LOG2-10), 2^(OSC_LOG2-5) or 2^OSC_LOG2 for codes 0, 1, 2 and 3. With the default parameters these are 32768 Hz, 1024 Hz, 32 Hz and 1 Hz.
- R5: Timer source codes 0, 1, 2 and 3 tick once per 2^(OSC_LOG2-12), 2^(OSC_LOG2-6), 2^OSC_LOG2 and SEC_PER_MIN·2^OSC_LOG2 oscillator rising edges. With the default parameters these are 4096 Hz, 64 Hz, 1 Hz and 1/60 Hz.
- R6: Writing the count register loads both the reload value and the live counter. Reading the count register returns the live counter. Each source tick while the timer is enabled decrements the counter. A tick that finds the counter at 1 (or 0) instead sets the flag and reloads the counter from the reload value, so the flag sets every N ticks for a count of N.
- R7: While the timer is disabled, the counter holds its value and the flag is not set.
- R8: The flag is cleared only by writing 0 to bit 2 of address 0x01. Writing 1 to that bit leaves the flag unchanged. An expiry in the same cycle as a clearing write leaves the flag set.
- R9: In level mode (bit 4 = 0) with the interrupt enabled, `intN` is low exactly while the flag is set.
- R10: In pulse mode with the interrupt enabled, `intN` goes low at an expiry and returns high at the next tick of the selected source, while the flag stays set.
- R11: With the interrupt enable at 0 in level mode, `intN` stays high whatever the flag is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| oscIn | input | 1 | Oscillator waveform, synchronous to clk |
| wrEn | input | 1 | Register write strobe |
| regAddr | input | 8 | Register address |
| wrData | input | 8 | Register write data |
| rdData | output | 8 | Read data for regAddr (combinational) |
| clkOut | output | 1 | Gated divided clock output |
| intN | output | 1 | Active-low timer interrupt |

## Verification
The hardest cases to reach from the ports are the two slow timer sources and the slow clock-out rates. At the real oscillator rate they need tens of thousands of rising edges per tick, and the minute source needs sixty seconds of ticks. The bench therefore builds the block with `OSC_LOG2` of 12 and `SEC_PER_MIN` of 3, so every rate keeps its relation to the oscillator while the minute tick arrives after 12288 edges. The prescaler phase is unknown when a test starts, so for each source the bench first waits for one expiry, clears the flag, and then checks that the next expiry comes exactly one period later and not one edge earlier. The coincidence of an expiry with a clearing write is reached by issuing the write in the same cycle as an oscillator rising edge while the counter is loaded with 1.

// File: rtl/rtc_pt_pkg.sv
package rtc_pt_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 8;
  localparam int SEL_W  = 2;

  localparam logic [ADDR_W-1:0] A_IRQ  = 8'h01;
  localparam logic [ADDR_W-1:0] A_CLKO = 8'h0D;
  localparam logic [ADDR_W-1:0] A_TCTL = 8'h0E;
  localparam logic [ADDR_W-1:0] A_TCNT = 8'h0F;

  localparam int B_EN    = 7;
  localparam int B_PULSE = 4;
  localparam int B_FLAG  = 2;
  localparam int B_TIE   = 0;

  typedef struct packed {
    logic              clkEn;
    logic [SEL_W-1:0]  clkSel;
    logic              tmrEn;
    logic [SEL_W-1:0]  tmrSel;
    logic              tie;
    logic              pulseMode;
    logic [DATA_W-1:0] reload;
  } cfg_t;

  typedef struct packed {
    logic              loadCnt;
    logic              flagWr;
    logic              flagKeep;
    logic [DATA_W-1:0] wrVal;
  } strobe_t;
endpackage

// File: rtl/rtc_pt_ctrl.sv
module rtc_pt_ctrl
  import rtc_pt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              flag,
  input  logic [DATA_W-1:0] counter,
  output cfg_t              cfg,
  output strobe_t           stb,
  output logic [DATA_W-1:0] rdData
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg <= '0;
    end else if (wrEn) begin
      case (regAddr)
        A_IRQ: begin
          cfg.tie       <= wrData[B_TIE];
          cfg.pulseMode <= wrData[B_PULSE];
        end
        A_CLKO: begin
          cfg.clkEn  <= wrData[B_EN];
          cfg.clkSel <= wrData[SEL_W-1:0];
        end
        A_TCTL: begin
          cfg.tmrEn  <= wrData[B_EN];
          cfg.tmrSel <= wrData[SEL_W-1:0];
        end
        A_TCNT: cfg.reload <= wrData;
        default: ;
      endcase
    end
  end

  always_comb begin
    stb.loadCnt  = wrEn && (regAddr == A_TCNT);
    stb.flagWr   = wrEn && (regAddr == A_IRQ);
    stb.flagKeep = wrData[B_FLAG];
    stb.wrVal    = wrData;
  end

  always_comb begin
    rdData = '0;
    case (regAddr)
      A_IRQ: begin
        rdData[B_TIE]   = cfg.tie;
        rdData[B_FLAG]  = flag;
        rdData[B_PULSE] = cfg.pulseMode;
      end
      A_CLKO: begin
        rdData[B_EN]        = cfg.clkEn;
        rdData[SEL_W-1:0]   = cfg.clkSel;
      end
      A_TCTL: begin
        rdData[B_EN]        = cfg.tmrEn;
        rdData[SEL_W-1:0]   = cfg.tmrSel;
      end
      A_TCNT: rdData = counter;
      default: ;
    endcase
  end

endmodule

// File: rtl/rtc_pt_datapath.sv
module rtc_pt_datapath
  import rtc_pt_pkg::*;
#(
  parameter int OSC_LOG2    = 15,
  parameter int SEC_PER_MIN = 60
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              oscIn,
  input  cfg_t              cfg,
  input  strobe_t           stb,
  output logic              flag,
  output logic [DATA_W-1:0] counter,
  output logic              clkOut,
  output logic              intN
);

  localparam int NRATE = 3;
  localparam int SEC_W = $clog2(SEC_PER_MIN);
  localparam logic [SEC_W-1:0] SEC_LAST = SEC_W'(SEC_PER_MIN - 1);
  // log2 of (oscillator / rate) is OSC_LOG2 - shift
  localparam int TICK_SHIFT [NRATE] = '{12, 6, 0};
  // clock-out tap bit is OSC_LOG2 - shift
  localparam int TAP_SHIFT  [NRATE] = '{11, 6, 1};

  logic                oscQ;
  logic                oscRise;
  logic [OSC_LOG2-1:0] pre;
  logic [OSC_LOG2-1:0] preNext;
  logic [SEC_W-1:0]    secCnt;
  logic [NRATE-1:0]    rateTick;
  logic [NRATE:0]      outTap;
  logic [NRATE:0]      tickSet;
  logic                minTick;
  logic                srcTick;
  logic                step;
  logic                expire;
  logic                pulseAct;

  assign oscRise   = oscIn & ~oscQ;
  assign preNext   = pre + 1'b1;
  assign outTap[0] = oscQ;

  for (genvar i = 0; i < NRATE; i++) begin : g_rate
    localparam logic [OSC_LOG2-1:0] MASK =
      OSC_LOG2'((1 << (OSC_LOG2 - TICK_SHIFT[i])) - 1);
    assign rateTick[i]  = oscRise && ((preNext & MASK) == '0);
    assign outTap[i+1]  = pre[OSC_LOG2 - TAP_SHIFT[i]];
  end

  assign minTick = rateTick[NRATE-1] && (secCnt == SEC_LAST);
  assign tickSet = {minTick, rateTick};
  assign srcTick = tickSet[cfg.tmrSel];
  assign step    = cfg.tmrEn && srcTick;
  assign expire  = step && (counter <= DATA_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      oscQ     <= 1'b0;
      pre      <= '0;
      secCnt   <= '0;
      counter  <= '0;
      flag     <= 1'b0;
      pulseAct <= 1'b0;
      clkOut   <= 1'b0;
    end else begin
      oscQ   <= oscIn;
      clkOut <= cfg.clkEn & outTap[cfg.clkSel];
      if (oscRise) pre <= preNext;
      if (rateTick[NRATE-1])
        secCnt <= (secCnt == SEC_LAST) ? '0 : secCnt + 1'b1;

      if (stb.loadCnt)  counter <= stb.wrVal;
      else if (step)    counter <= expire ? cfg.reload : counter - 1'b1;

      if (expire)                             flag <= 1'b1;
      else if (stb.flagWr && !stb.flagKeep)   flag <= 1'b0;

      if (expire && cfg.tie && cfg.pulseMode) pulseAct <= 1'b1;
      else if (srcTick)                       pulseAct <= 1'b0;
    end
  end

  assign intN = !((cfg.tie && !cfg.pulseMode && flag) ||
                  (cfg.pulseMode && pulseAct));

endmodule

// File: rtl/rtc_prescale_timer.sv
module rtc_prescale_timer
  import rtc_pt_pkg::*;
#(
  parameter int OSC_LOG2    = 15,
  parameter int SEC_PER_MIN = 60
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              oscIn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              clkOut,
  output logic              intN
);

  cfg_t              cfg;
  strobe_t           stb;
  logic              flag;
  logic [DATA_W-1:0] counter;

  rtc_pt_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .regAddr (regAddr),
    .wrData  (wrData),
    .flag    (flag),
    .counter (counter),
    .cfg     (cfg),
    .stb     (stb),
    .rdData  (rdData)
  );

  rtc_pt_datapath #(
    .OSC_LOG2    (OSC_LOG2),
    .SEC_PER_MIN (SEC_PER_MIN)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .oscIn   (oscIn),
    .cfg     (cfg),
    .stb     (stb),
    .flag    (flag),
    .counter (counter),
    .clkOut  (clkOut),
    .intN    (intN)
  );

endmodule

// File: rtl/rtc_prescale_timer_chk.sv
module rtc_prescale_timer_chk
  import rtc_pt_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input cfg_t              cfg,
  input strobe_t           stb,
  input logic              flag,
  input logic [DATA_W-1:0] counter,
  input logic              clkOut,
  input logic              intN
);

  a_r3_clkout_low: assert property (@(posedge clk) disable iff (!rstN)
    !cfg.clkEn |=> !clkOut);

  a_r7_hold_counter: assert property (@(posedge clk) disable iff (!rstN)
    (!cfg.tmrEn && !stb.loadCnt) |=> $stable(counter));

  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (flag && !(stb.flagWr && !stb.flagKeep)) |=> flag);

  a_r11_irq_masked: assert property (@(posedge clk) disable iff (!rstN)
    (!cfg.tie && !cfg.pulseMode) |-> intN);

  a_r6_flag_needs_timer: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flag) |-> $past(cfg.tmrEn));

  a_r6_load_count: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadCnt |=> (counter == $past(stb.wrVal)));

endmodule

bind rtc_prescale_timer rtc_prescale_timer_chk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .cfg     (cfg),
  .stb     (stb),
  .flag    (flag),
  .counter (counter),
  .clkOut  (clkOut),
  .intN    (intN)
);

// File: tb/rtc_prescale_timer_test.sv
module rtc_prescale_timer_test;
  localparam int L   = 12;
  localparam int SPM = 3;
  localparam int PER [4] = '{1 << (L - 12), 1 << (L - 6), 1 << L, SPM << L};
  // {address, write data, expected read-back}
  localparam int NVEC = 11;
  localparam logic [23:0] VEC [NVEC] = '{
    {8'h01, 8'hFF, 8'h11}, {8'h01, 8'h00, 8'h00},
    {8'h0D, 8'hFF, 8'h83}, {8'h0D, 8'h7E, 8'h02},
    {8'h0D, 8'h00, 8'h00}, {8'h0E, 8'hFE, 8'h82},
    {8'h0E, 8'h00, 8'h00}, {8'h0F, 8'hA5, 8'hA5},
    {8'h05, 8'hFF, 8'h00}, {8'h00, 8'hFF, 8'h00},
    {8'hFF, 8'hFF, 8'h00}
  };

  logic       clk = 1'b0;
  logic       rstN;
  logic       oscIn;
  logic       wrEn;
  logic [7:0] regAddr;
  logic [7:0] wrData;
  logic [7:0] rdData;
  logic       clkOut;
  logic       intN;

  int  nChecks = 0;
  int  nFails  = 0;
  int  riseCnt = 0;
  logic prevClk = 1'b0;
  bit  finished = 1'b0;

  always #4 clk = ~clk;

  rtc_prescale_timer #(.OSC_LOG2(L), .SEC_PER_MIN(SPM)) uut (
    .clk(clk), .rstN(rstN), .oscIn(oscIn), .wrEn(wrEn),
    .regAddr(regAddr), .wrData(wrData), .rdData(rdData),
    .clkOut(clkOut), .intN(intN)
  );

  always @(negedge clk) begin
    if (clkOut && !prevClk) riseCnt = riseCnt + 1;
    prevClk = clkOut;
  end

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); wrEn = 1'b1; regAddr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    @(negedge clk); regAddr = a; #1; v = rdData;
  endtask

  task automatic oscStep();
    @(negedge clk); oscIn = 1'b1;
    @(negedge clk); oscIn = 1'b0;
  endtask

  task automatic measure(input int steps, output int rises);
    int start;
    repeat (4) @(negedge clk);
    start = riseCnt;
    repeat (steps) oscStep();
    repeat (4) @(negedge clk);
    rises = riseCnt - start;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog (R1..all) actual=timeout expected=completion");
      summary();
    end
  end

  initial begin
    logic [7:0] v;
    int rises;
    bit found;
    rstN = 1'b0; oscIn = 1'b0; wrEn = 1'b0; regAddr = '0; wrData = '0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(8'h01, v); check("R1 irq ctl", v, 8'h00);
    rd(8'h0D, v); check("R1 clkout ctl", v, 8'h00);
    rd(8'h0E, v); check("R1 timer ctl", v, 8'h00);
    rd(8'h0F, v); check("R1 count", v, 8'h00);
    check("R1 clkOut", clkOut, 0);
    check("R1 intN", intN, 1);

    // R2 register map vectors
    for (int i = 0; i < NVEC; i++) begin
      wr(VEC[i][23:16], VEC[i][15:8]);
      rd(VEC[i][23:16], v);
      check($sformatf("R2 vec %0d", i), v, VEC[i][7:0]);
    end
    rd(8'h0F, v); check("R2 count after unused writes", v, 8'hA5);
    rd(8'h0D, v); check("R2 clkout after unused writes", v, 8'h00);
    rd(8'h01, v); check("R2 irq after unused writes", v, 8'h00);

    // R3 disabled clock-out
    measure(40, rises); check("R3 disabled rises", rises, 0);
    check("R3 clkOut low", clkOut, 0);

    // R4 clock-out rates
    wr(8'h0D, 8'h80); measure(16, rises);   check("R4 sel0", rises, 16);
    wr(8'h0D, 8'h81); measure(64, rises);   check("R4 sel1", rises, 64 / (1 << (L - 10)));
    wr(8'h0D, 8'h82); measure(512, rises);  check("R4 sel2", rises, 512 / (1 << (L - 5)));
    wr(8'h0D, 8'h83); measure(8192, rises); check("R4 sel3", rises, 8192 / (1 << L));
    wr(8'h0D, 8'h00);

    // R6 countdown and reload, R11 masked
    wr(8'h01, 8'h00); wr(8'h0F, 8'd3); wr(8'h0E, 8'h80);
    oscStep(); oscStep();
    rd(8'h01, v); check("R6 no flag before expiry", v[2], 0);
    rd(8'h0F, v); check("R6 live count", v, 1);
    oscStep();
    rd(8'h01, v); check("R6 flag at expiry", v[2], 1);
    rd(8'h0F, v); check("R6 reloaded", v, 3);
    check("R11 intN masked", intN, 1);

    // R8 clear only by zero
    wr(8'h01, 8'h04); rd(8'h01, v); check("R8 write one keeps", v, 8'h04);
    wr(8'h01, 8'h00); rd(8'h01, v); check("R8 write zero clears", v, 8'h00);

    // R9 level mode
    wr(8'h01, 8'h01);
    repeat (3) oscStep(); check("R9 low at expiry", intN, 0);
    repeat (3) oscStep(); check("R9 stays low", intN, 0);
    wr(8'h01, 8'h01); check("R9 high after clear", intN, 1);

    // R10 pulse mode
    wr(8'h01, 8'h11);
    oscStep(); oscStep(); check("R10 high before expiry", intN, 1);
    oscStep(); check("R10 low at expiry", intN, 0);
    rd(8'h01, v); check("R10 flag set", v, 8'h15);
    oscStep(); check("R10 released next tick", intN, 1);
    rd(8'h01, v); check("R10 flag kept", v, 8'h15);

    // R8 expiry beats clearing write
    wr(8'h01, 8'h00); wr(8'h0F, 8'd1);
    oscStep(); rd(8'h01, v); check("R8 flag before race", v, 8'h04);
    @(negedge clk); oscIn = 1'b1; wrEn = 1'b1; regAddr = 8'h01; wrData = 8'h00;
    @(negedge clk); oscIn = 1'b0; wrEn = 1'b0;
    rd(8'h01, v); check("R8 expiry wins", v, 8'h04);
    wr(8'h01, 8'h00); rd(8'h01, v); check("R8 cleared", v, 8'h00);

    // R7 disabled timer
    wr(8'h0E, 8'h00); wr(8'h0F, 8'd4);
    repeat (10) oscStep();
    rd(8'h0F, v); check("R7 count held", v, 4);
    rd(8'h01, v); check("R7 no flag", v, 8'h00);

    // R5 source periods
    for (int s = 0; s < 4; s++) begin
      wr(8'h0E, 8'h00); wr(8'h0F, 8'd1); wr(8'h01, 8'h00);
      wr(8'h0E, 8'h80 | 8'(s));
      found = 1'b0;
      for (int k = 0; k <= PER[s] && !found; k++) begin
        oscStep(); rd(8'h01, v);
        if (v[2]) found = 1'b1;
      end
      check($sformatf("R5 sel%0d first expiry", s), found, 1);
      wr(8'h01, 8'h00);
      repeat (PER[s] - 1) oscStep();
      rd(8'h01, v); check($sformatf("R5 sel%0d not early", s), v[2], 0);
      oscStep();
      rd(8'h01, v); check($sformatf("R5 sel%0d on period", s), v[2], 1);
    end

    finished = 1'b1;
    summary();
  end
endmodule